// File: doc/BRIEF.md
# Paged Parallel EEPROM Write Sequencer

This block is a synchronous controller that drives the write side of a byte-wide parallel EEPROM. A host hands it bytes over a valid/ready request port. Each request carries an address, a data byte and a flag that marks the final byte of a page. The block drives active-low chip select, write enable and output enable, and it drives the address and data buses. Every timing minimum of the memory is given as a parameter in nanoseconds. Each one is turned into a whole number of clock cycles by ceiling division by the clock period parameter.

Chip select stays low for the whole page, and write enable is the strobe that pulses once per byte. The memory restarts its page window timer on every falling strobe. Each further byte of the page must therefore show its falling strobe within that window. If the host is too slow for this, the block closes the page on its own. After a page closes, the block waits out the worst-case programming time. It then accepts the next request.

Top module: `eew_seq`

## Requirements
- R1: Out of reset, chip select, write enable and output enable are high, busy is low and the request port is ready.
- R2: Output enable is high at every moment, including every cycle in which write enable is low.
- R3: Each write-enable low pulse lasts exactly N_WP = max(ceil(T_WP/CLK), ceil(T_DS/CLK)) cycles.
- R4: Between two pulses of one page, write enable stays high for at least N_HO + N_SU cycles. Here N_SU = max(ceil(T_OES/CLK), ceil(T_AS/CLK), ceil(T_CS/CLK), 1) and N_HO = max(ceil(T_DH/CLK), ceil(T_WPH/CLK), ceil(T_OEH/CLK), ceil(T_AH/CLK) − N_WP, 1).
- R5: The address and data of each pulse are those of the accepted requests, in acceptance order. They are constant while write enable is low. They are still in place in the first cycle after the rising strobe. They have been stable for at least ceil(T_DS/CLK) cycles when write enable rises.
- R6: Write enable is low only while chip select is low. Chip select stays low, without a break, from the first byte of a page to its last.
- R7: Falling strobes of successive bytes in one page are at most N_PG = ceil(T_PAGE/CLK) cycles apart. If no request arrives early enough to meet that limit, chip select returns high and the page is closed.
- R8: After a page that ends with the last flag, busy falls exactly N_HO + N_WC cycles after the final rising strobe, where N_WC = ceil(T_WC/CLK). No pulse of a later page falls sooner than N_WC cycles after the final rising strobe of the previous page.
- R9: Request ready is low while write enable is low and throughout the post-page wait. A request held valid during the wait is taken in the first cycle that busy is low.
- R10: Busy is high whenever chip select is low, and it stays high until the post-page wait ends.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Request holds a byte to write |
| req_ready | output | 1 | Block takes the request on this edge |
| req_addr | input | AW | Byte address |
| req_data | input | DW | Byte to write |
| req_last | input | 1 | Final byte of the page |
| ee_cs_n | output | 1 | Memory chip select, active low |
| ee_we_n | output | 1 | Memory write strobe, active low |
| ee_oe_n | output | 1 | Memory output enable, active low |
| ee_addr | output | AW | Memory address bus |
| ee_data | output | DW | Memory data bus |
| busy | output | 1 | A page or its programming wait is in progress |

## Verification
The bench runs a 5 ns clock. It builds the block with a 151 ns pulse-width minimum, so that the ceiling division rounds up to 31 cycles. The page window is shortened to 1000 ns (200 cycles) and the programming time to 2000 ns (400 cycles). With these short times, a slow byte that closes the page, a held request during the wait, and the exact busy release can all be reached within a short run. The other timing minimums keep their default values. This makes the hold phase depend on the write-high minimum, not on the address hold minimum.

// File: rtl/eew_pkg.sv
package eew_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_LOW,
    ST_HOLD,
    ST_GAP,
    ST_WAIT
  } eew_state_e;

  // ceiling conversion of a nanosecond minimum into clock cycles
  function automatic int unsigned ns2cyc(input int unsigned ns, input int unsigned clk_ns);
    return (ns + clk_ns - 1) / clk_ns;
  endfunction

  function automatic int unsigned umax(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/eew_rst_sync.sv
module eew_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/eew_timer.sv
module eew_timer #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic [W-1:0] cnt,
  output logic         zero
);
  logic [W-1:0] cnt_d, cnt_q;
  logic         cnt_en;

  always_comb begin
    cnt_en = load || (cnt_q != '0);
    cnt_d  = load ? load_val : (cnt_q - 1'b1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt  = cnt_q;
  assign zero = (cnt_q == '0);

  // the counter saturates at zero instead of wrapping (supports R3/R7/R8 timing)
  p_sat_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && cnt_q == '0) |=> (cnt_q == '0));
endmodule

// File: rtl/eew_seq.sv
module eew_seq
  import eew_pkg::*;
#(
  parameter int unsigned AW        = 17,
  parameter int unsigned DW        = 8,
  parameter int unsigned CLK_NS    = 5,
  parameter int unsigned T_WP_NS   = 150,
  parameter int unsigned T_WPH_NS  = 50,
  parameter int unsigned T_DS_NS   = 100,
  parameter int unsigned T_DH_NS   = 10,
  parameter int unsigned T_AS_NS   = 0,
  parameter int unsigned T_AH_NS   = 100,
  parameter int unsigned T_CS_NS   = 0,
  parameter int unsigned T_OES_NS  = 10,
  parameter int unsigned T_OEH_NS  = 10,
  parameter int unsigned T_PAGE_NS = 150000,
  parameter int unsigned T_WC_NS   = 10000000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_data,
  input  logic          req_last,
  output logic          ee_cs_n,
  output logic          ee_we_n,
  output logic          ee_oe_n,
  output logic [AW-1:0] ee_addr,
  output logic [DW-1:0] ee_data,
  output logic          busy
);

  // cycle counts derived from the nanosecond minimums
  localparam int unsigned C_WP  = ns2cyc(T_WP_NS, CLK_NS);
  localparam int unsigned C_DS  = ns2cyc(T_DS_NS, CLK_NS);
  localparam int unsigned C_AH  = ns2cyc(T_AH_NS, CLK_NS);
  localparam int unsigned N_SU  = umax(umax(ns2cyc(T_OES_NS, CLK_NS), ns2cyc(T_AS_NS, CLK_NS)),
                                       umax(ns2cyc(T_CS_NS, CLK_NS), 1));
  localparam int unsigned N_WP  = umax(umax(C_WP, C_DS), 1);
  localparam int unsigned AH_X  = (C_AH > N_WP) ? (C_AH - N_WP) : 0;
  localparam int unsigned N_HO  = umax(umax(ns2cyc(T_DH_NS, CLK_NS), ns2cyc(T_WPH_NS, CLK_NS)),
                                       umax(ns2cyc(T_OEH_NS, CLK_NS), umax(AH_X, 1)));
  localparam int unsigned N_PG  = umax(ns2cyc(T_PAGE_NS, CLK_NS), N_SU + 1);
  localparam int unsigned N_WC  = umax(ns2cyc(T_WC_NS, CLK_NS), 1);
  localparam int unsigned PW    = $clog2(umax(N_WC, umax(N_WP, umax(N_HO, N_SU))) + 1);
  localparam int unsigned GW    = $clog2(N_PG + 1);

  logic          rst_q_n;
  eew_state_e    state_q, state_d;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q;
  logic          last_q;
  logic          accept;
  logic          ph_load, ph_zero, win_load, win_zero;
  logic [PW-1:0] ph_val, ph_cnt;
  logic [GW-1:0] win_cnt;
  logic          win_open;

  eew_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_q_n));

  // phase timer: setup, strobe low, hold and programming wait
  eew_timer #(.W(PW)) u_phase (
    .clk(clk), .rst_n(rst_q_n), .load(ph_load), .load_val(ph_val),
    .cnt(ph_cnt), .zero(ph_zero));

  // page window timer, restarted on every falling strobe
  eew_timer #(.W(GW)) u_window (
    .clk(clk), .rst_n(rst_q_n), .load(win_load), .load_val(GW'(N_PG)),
    .cnt(win_cnt), .zero(win_zero));

  // a byte taken now falls N_SU cycles later; it must land inside the window
  assign win_open  = !win_zero && (win_cnt > GW'(N_SU));
  assign req_ready = (state_q == ST_IDLE) || ((state_q == ST_GAP) && win_open);
  assign accept    = req_valid && req_ready;

  always_comb begin
    state_d  = state_q;
    ph_load  = 1'b0;
    ph_val   = '0;
    win_load = 1'b0;
    unique case (state_q)
      ST_IDLE: if (accept) begin
        state_d = ST_SETUP; ph_load = 1'b1; ph_val = PW'(N_SU - 1);
      end
      ST_SETUP: if (ph_zero) begin
        state_d = ST_LOW; ph_load = 1'b1; ph_val = PW'(N_WP - 1); win_load = 1'b1;
      end
      ST_LOW: if (ph_zero) begin
        state_d = ST_HOLD; ph_load = 1'b1; ph_val = PW'(N_HO - 1);
      end
      ST_HOLD: if (ph_zero) begin
        if (last_q) begin
          state_d = ST_WAIT; ph_load = 1'b1; ph_val = PW'(N_WC - 1);
        end else begin
          state_d = ST_GAP;
        end
      end
      ST_GAP: begin
        if (accept) begin
          state_d = ST_SETUP; ph_load = 1'b1; ph_val = PW'(N_SU - 1);
        end else if (!win_open) begin
          state_d = ST_WAIT; ph_load = 1'b1; ph_val = PW'(N_WC - 1);
        end
      end
      ST_WAIT: if (ph_zero) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) state_q <= ST_IDLE;
    else          state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      addr_q <= '0;
      data_q <= '0;
      last_q <= 1'b0;
    end else if (accept) begin
      addr_q <= req_addr;
      data_q <= req_data;
      last_q <= req_last;
    end
  end

  assign ee_cs_n = !((state_q == ST_SETUP) || (state_q == ST_LOW) ||
                     (state_q == ST_HOLD)  || (state_q == ST_GAP));
  assign ee_we_n = (state_q != ST_LOW);
  assign ee_oe_n = 1'b1;
  assign ee_addr = addr_q;
  assign ee_data = data_q;
  assign busy    = (state_q != ST_IDLE);

  p_we_in_page_r6: assert property (@(posedge clk) disable iff (!rst_q_n)
    !ee_we_n |-> !ee_cs_n);
  p_busy_in_page_r10: assert property (@(posedge clk) disable iff (!rst_q_n)
    !ee_cs_n |-> busy);
  p_no_take_in_strobe_r9: assert property (@(posedge clk) disable iff (!rst_q_n)
    !ee_we_n |-> !req_ready);
  p_no_take_in_wait_r9: assert property (@(posedge clk) disable iff (!rst_q_n)
    (state_q == ST_WAIT) |-> !req_ready);
  p_bus_stable_r5: assert property (@(posedge clk) disable iff (!rst_q_n)
    (!ee_we_n && $past(!ee_we_n)) |-> ($stable(ee_data) && $stable(ee_addr)));
  p_hold_after_rise_r5: assert property (@(posedge clk) disable iff (!rst_q_n)
    $rose(ee_we_n) |-> ($stable(ee_data) && $stable(ee_addr)));
endmodule

// File: tb/tb_eew_seq.sv
module tb_eew_seq;
  localparam int AW = 17;
  localparam int DW = 8;
  localparam int CLK_NS = 5;
  localparam int WP_NS = 151, WPH_NS = 50, DS_NS = 100, DH_NS = 10, AH_NS = 100;
  localparam int OES_NS = 10, OEH_NS = 10, PAGE_NS = 1000, WC_NS = 2000;

  function automatic int cy(input int ns);
    return (ns + CLK_NS - 1) / CLK_NS;
  endfunction
  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int E_SU = 2;    // ceil(10/5)
  localparam int E_WP = 31;   // ceil(151/5) beats ceil(100/5)
  localparam int E_HO = 10;   // ceil(50/5) beats 2, 2 and 20-31
  localparam int E_PG = 200;
  localparam int E_WC = 400;
  localparam int E_DS = 20;

  logic clk, rst_n;
  logic req_valid, req_ready, req_last;
  logic [AW-1:0] req_addr;
  logic [DW-1:0] req_data;
  logic ee_cs_n, ee_we_n, ee_oe_n, busy;
  logic [AW-1:0] ee_addr;
  logic [DW-1:0] ee_data;

  eew_seq #(.AW(AW), .DW(DW), .CLK_NS(CLK_NS), .T_WP_NS(WP_NS), .T_PAGE_NS(PAGE_NS),
            .T_WC_NS(WC_NS)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_data(req_data), .req_last(req_last),
    .ee_cs_n(ee_cs_n), .ee_we_n(ee_we_n), .ee_oe_n(ee_oe_n),
    .ee_addr(ee_addr), .ee_data(ee_data), .busy(busy));

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  int tests = 0, fails = 0;
  int cyc = 0;
  logic [AW+DW-1:0] sb_q[$];
  bit done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d (t=%0d)", req, act, exp, cyc);
    end
  endtask

  // ---------------- driver ----------------
  int accept_t;
  task automatic send(input logic [AW-1:0] a, input logic [DW-1:0] d, input bit last);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_data = d; req_last = last;
    while (!req_ready) @(negedge clk);
    accept_t = cyc;
    sb_q.push_back({a, d});
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // ---------------- monitor ----------------
  bit mon_on = 0, prev_we = 1, prev_cs = 1, prev_busy = 0, in_page = 0, had_page = 0;
  int fall_t, rise_t, chg_t, busy_fall_t, pages = 0, cs_fall_t;
  logic [AW-1:0] p_addr;
  logic [DW-1:0] p_data;

  always @(negedge clk) begin
    if (mon_on) begin
      if (ee_addr !== p_addr || ee_data !== p_data) chg_t = cyc;
      if (prev_we && !ee_we_n) begin
        chk(ee_oe_n === 1'b1, "R2 oe high at strobe", ee_oe_n, 1);
        chk(busy === 1'b1, "R10 busy during page", busy, 1);
        if (in_page) begin
          chk(cyc - fall_t <= E_PG, "R7 fall spacing", cyc - fall_t, E_PG);
          chk(cyc - rise_t >= E_HO + E_SU, "R4 high time", cyc - rise_t, E_HO + E_SU);
        end else if (had_page) begin
          chk(cyc - rise_t >= E_WC, "R8 post-page wait", cyc - rise_t, E_WC);
        end
        in_page = 1; fall_t = cyc;
      end
      if (!prev_we && !ee_we_n)
        chk(ee_addr === p_addr && ee_data === p_data, "R5 bus stable in pulse", ee_data, p_data);
      if (!prev_we && ee_we_n) begin
        logic [AW+DW-1:0] exp_v;
        rise_t = cyc;
        chk(cyc - fall_t == E_WP, "R3 pulse width", cyc - fall_t, E_WP);
        chk(cyc - chg_t >= E_DS + 1, "R5 data setup", cyc - chg_t, E_DS + 1);
        if (sb_q.size() == 0) chk(0, "R5 unexpected byte", ee_data, -1);
        else begin
          exp_v = sb_q.pop_front();
          chk({ee_addr, ee_data} === exp_v, "R5 byte order", {ee_addr, ee_data}, exp_v);
        end
      end
      if (!ee_we_n && ee_cs_n) chk(0, "R6 strobe outside page", ee_cs_n, 0);
      if (prev_cs && !ee_cs_n) cs_fall_t = cyc;
      if (!prev_cs && ee_cs_n) begin
        in_page = 0; had_page = 1; pages++;
      end
      if (prev_busy && !busy) busy_fall_t = cyc;
      prev_we = ee_we_n; prev_cs = ee_cs_n; prev_busy = busy;
      p_addr = ee_addr; p_data = ee_data;
    end
  end

  task automatic wait_rise();
    @(negedge clk);
    while (!(ee_we_n && !prev_we)) @(negedge clk);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  initial begin
    int t0, pages0;
    bit rdy_seen;
    req_valid = 0; req_addr = '0; req_data = '0; req_last = 0;
    rst_n = 0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(ee_cs_n === 1 && ee_we_n === 1 && ee_oe_n === 1, "R1 strobes idle",
        {ee_cs_n, ee_we_n, ee_oe_n}, 7);
    chk(busy === 0, "R1 busy low", busy, 0);
    chk(req_ready === 1, "R1 ready high", req_ready, 1);
    p_addr = ee_addr; p_data = ee_data; chg_t = cyc;
    mon_on = 1;

    // page A: four bytes back to back, last flag closes the page (R3 R4 R5 R6 R8)
    send(17'h00100, 8'hA5, 0);
    send(17'h00101, 8'h5A, 0);
    send(17'h00102, 8'h3C, 0);
    send(17'h00103, 8'hC3, 1);
    wait_rise();
    t0 = cyc;
    rdy_seen = 0;
    while (busy) begin
      if (req_ready && ee_cs_n) rdy_seen = 1;
      @(negedge clk);
    end
    chk(cyc - t0 == E_HO + E_WC, "R8 busy release", cyc - t0, E_HO + E_WC);
    chk(!rdy_seen, "R9 ready low in wait", rdy_seen, 0);
    chk(pages == 1, "R6 one page for A", pages, 1);

    // page B: slow host but inside the window; the page must stay open (R6 R7)
    pages0 = pages;
    send(17'h1F000, 8'h11, 0);
    repeat (60) @(negedge clk);
    send(17'h1F001, 8'h22, 0);
    repeat (100) @(negedge clk);
    send(17'h1F002, 8'h33, 1);
    wait_rise();
    chk(pages == pages0, "R6 chip select unbroken in page", pages - pages0, 0);
    while (busy) @(negedge clk);
    chk(pages == pages0 + 1, "R6 page B closed once", pages - pages0, 1);

    // page C: no last flag, host stalls past the window (R7)
    send(17'h00777, 8'h77, 0);
    while (ee_we_n) @(negedge clk);
    t0 = cyc;
    repeat (E_PG + 2) @(negedge clk);
    chk(ee_cs_n === 1, "R7 page closed by window", ee_cs_n, 1);
    chk(busy === 1, "R10 busy through wait", busy, 1);
    // page D request held during the wait (R9)
    send(17'h00888, 8'h88, 1);
    chk(accept_t == busy_fall_t, "R9 held request taken at idle", accept_t, busy_fall_t);
    while (busy) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(sb_q.size() == 0, "R5 all bytes written", sb_q.size(), 0);
    chk(busy === 0 && req_ready === 1, "R10 idle at end", busy, 0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule